// File: doc/BRIEF.md
# Edge-Selectable GPIO Interrupt Port

This block is a byte-wide general-purpose I/O port for an interrupt-driven system. Every bit can be set as an input or an output. A CPU reaches the port through a small register interface with three registers: a direction register, an active-edge register and a data register. Output bits drive the latched data onto the pins, and the block also supplies an output-enable vector for the pad ring.

Input pins first pass through a two-stage synchronizer. The block keeps the last level it sampled on each input bit. A bit sees an edge when that stored level differs from the bit's active-edge setting and the new synchronized level matches it. The active-edge setting therefore picks the polarity per bit: 1 selects rising and 0 selects falling.

Each detected edge becomes a one-clock request pulse on that bit's line toward an interrupt controller. The pulse is sent only when the controller's enable bit for that line is high.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the direction, active-edge and data registers are 0, `pin_o` and `pin_oe_o` are 0, and no request pulse is driven.
- R2: The register select codes are 0 for data, 1 for direction and 2 for active edge. A write is applied at the next rising clock edge. Reading code 3 returns 0x00, and a write to code 3 changes nothing.
- R3: `pin_oe_o` equals the direction register. `pin_o` carries the data register on bits whose direction is 1 and 0 on all other bits.
- R4: A data write stores the written value only on bits whose direction bit is 1 at the time of the write. The data bits of input-direction bits are cleared.
- R5: A read of the data register returns the synchronized pin level on input bits and the stored data bit on output bits.
- R6: With its active-edge bit at 1, an input bit raises a one-cycle request on a 0-to-1 pin change. The pulse is high at the third rising clock edge after the pin changes (two synchronizer stages plus one output register).
- R7: With its active-edge bit at 0, an input bit raises a one-cycle request on a 1-to-0 change, with the same latency as R6. The opposite transition raises nothing.
- R8: A detected edge gives no pulse when the bit's enable input is low in that cycle. Such an edge is not stored, so a later enable produces no delayed pulse.
- R9: A bit whose direction is 1 never raises a request, whatever its pin does.
- R10: The stored level follows the pin on every cycle. A pin held at its new level produces exactly one pulse, and pulses on several bits in the same cycle are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_sel_i | input | 2 | Register select (0 data, 1 direction, 2 active edge) |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data for the selected register |
| pin_i | input | 8 | External pin levels, asynchronous |
| pin_o | output | 8 | Driven pin values |
| pin_oe_o | output | 8 | Per-bit output enable |
| irq_en_i | input | 8 | Per-bit request enable from the interrupt controller |
| irq_o | output | 8 | One-clock edge request pulses |

## Verification
The stored pin level is the state most likely to go wrong. If it is stale, a held level gives a second pulse one cycle after the first, or a transition in the wrong direction gives a pulse, and either shows up within four cycles of the pin change. A bad direction or data register is visible in the same cycle on `pin_oe_o`, `pin_o` and the data readback. A mistake in edge polarity or enable gating shows as a pulse that is missing or extra at exactly the third clock after the stimulus.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_EDGE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stage[s] = st_q.stage[s-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.stage[LAST];

    // R6: the synchronizer output is the first stage delayed by one further cycle
    a_r6_sync_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ##1 sync_o == $past(st_q.stage[LAST-1]));

endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] pin_sync_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [WIDTH-1:0] dir_o,
    output logic [WIDTH-1:0] edge_o,
    output logic [WIDTH-1:0] data_o
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] act;
    } regs_state_t;

    regs_state_t st_d, st_q;
    reg_sel_e    sel;

    assign sel = reg_sel_e'(sel_i);

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            unique case (sel)
                SEL_DATA: st_d.data = wdata_i & st_q.dir;
                SEL_DIR:  st_d.dir  = wdata_i;
                SEL_EDGE: st_d.act  = wdata_i;
                default:  st_d      = st_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        unique case (sel)
            SEL_DATA: rdata_o = (pin_sync_i & ~st_q.dir) | (st_q.data & st_q.dir);
            SEL_DIR:  rdata_o = st_q.dir;
            SEL_EDGE: rdata_o = st_q.act;
            default:  rdata_o = '0;
        endcase
    end

    assign dir_o  = st_q.dir;
    assign edge_o = st_q.act;
    assign data_o = st_q.data;

    // R2: a direction write lands at the next edge
    a_r2_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && sel_i == 2'd1) |=> dir_o == $past(wdata_i));

    // R2: a write to the unused code leaves every register unchanged
    a_r2_none_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && sel_i == 2'd3) |=> ($stable(dir_o) && $stable(edge_o) && $stable(data_o)));

    // R4: a data write never sets a bit that was an input at write time
    a_r4_data_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && sel_i == 2'd0) |=> (data_o & ~$past(dir_o)) == '0);

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] edge_sel_i,
    input  logic [WIDTH-1:0] en_i,
    output logic [WIDTH-1:0] irq_o
);
    typedef struct packed {
        logic [WIDTH-1:0] last;
        logic [WIDTH-1:0] irq;
    } det_state_t;

    det_state_t       st_d, st_q;
    logic [WIDTH-1:0] hit;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            hit[b] = !dir_i[b]
                  && (st_q.last[b] != edge_sel_i[b])
                  && (level_i[b]   == edge_sel_i[b]);
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.irq  = hit & en_i;
        st_d.last = level_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R10: the stored level tracks the synchronized pin every cycle
    a_r10_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ##1 st_q.last == $past(level_i));

    // R10: a request never lasts longer than one cycle
    a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ##1 ((irq_o & $past(irq_o)) == '0));

    // R8: no pulse on a bit whose enable was low
    a_r8_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ##1 ((irq_o & ~$past(en_i)) == '0));

    // R9: output bits never pulse
    a_r9_out_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ##1 ((irq_o & $past(dir_i)) == '0));

    // R6/R7: a pulsing bit's new level equals its active-edge setting
    a_r6_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ##1 (((st_q.last ^ $past(edge_sel_i)) & irq_o) == '0));

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cpu_wr_i,
    input  logic [1:0]       cpu_sel_i,
    input  logic [WIDTH-1:0] cpu_wdata_i,
    output logic [WIDTH-1:0] cpu_rdata_o,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_o,
    output logic [WIDTH-1:0] pin_oe_o,
    input  logic [WIDTH-1:0] irq_en_i,
    output logic [WIDTH-1:0] irq_o
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] edge_q;
    logic [WIDTH-1:0] data_q;

    gpio_edge_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    gpio_edge_regs #(
        .WIDTH (WIDTH)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (cpu_wr_i),
        .sel_i      (cpu_sel_i),
        .wdata_i    (cpu_wdata_i),
        .pin_sync_i (pin_sync),
        .rdata_o    (cpu_rdata_o),
        .dir_o      (dir_q),
        .edge_o     (edge_q),
        .data_o     (data_q)
    );

    gpio_edge_detect #(
        .WIDTH (WIDTH)
    ) u_detect (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .level_i    (pin_sync),
        .dir_i      (dir_q),
        .edge_sel_i (edge_q),
        .en_i       (irq_en_i),
        .irq_o      (irq_o)
    );

    assign pin_oe_o = dir_q;
    assign pin_o    = data_q & dir_q;

    // R3: a driven pin is always one whose output enable is set
    a_r3_drive_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_o & ~pin_oe_o) == '0);

endmodule

// File: tb/gpio_edge_port_tb_top.sv
module gpio_edge_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] en = 8'h00;
    logic [7:0] irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    gpio_edge_port dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cpu_wr_i    (wr),
        .cpu_sel_i   (sel),
        .cpu_wdata_i (wdata),
        .cpu_rdata_o (rdata),
        .pin_i       (pin_in),
        .pin_o       (pin_out),
        .pin_oe_o    (pin_oe),
        .irq_en_i    (en),
        .irq_o       (irq)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        wr = 1'b1; sel = s; wdata = v;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        sel = s;
        #1 v = rdata;
    endtask

    // change pins at a falling edge, then check the request on the five following falling edges
    task automatic pin_pulse(input string req, input logic [7:0] new_pins, input logic [7:0] exp);
        @(negedge clk);
        pin_in = new_pins;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            if (c == 3) check8(req, irq, exp);
            else        check8(req, irq, 8'h00);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check8("R1 pin_o", pin_out, 8'h00);
        check8("R1 pin_oe", pin_oe, 8'h00);
        check8("R1 irq", irq, 8'h00);
        reg_read(2'd1, v); check8("R1 dir", v, 8'h00);
        reg_read(2'd2, v); check8("R1 edge", v, 8'h00);
        reg_read(2'd0, v); check8("R1 data", v, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        reg_write(2'd2, 8'h5A);
        reg_read(2'd2, v); check8("R2 edge rw", v, 8'h5A);
        reg_write(2'd3, 8'hFF);
        reg_read(2'd3, v); check8("R2 code3 reads 0", v, 8'h00);
        reg_read(2'd1, v); check8("R2 code3 write ignored dir", v, 8'h00);
        reg_read(2'd2, v); check8("R2 code3 write ignored edge", v, 8'h5A);
        check8("R2 code3 write ignored pins", pin_oe, 8'h00);
        reg_write(2'd2, 8'h00);
    endtask

    task automatic t_drive();
        logic [7:0] v;
        reg_write(2'd1, 8'h0F);
        check8("R3 oe", pin_oe, 8'h0F);
        reg_write(2'd0, 8'hFF);
        check8("R3 pin_o", pin_out, 8'h0F);
        reg_write(2'd1, 8'hFF);
        check8("R4 masked data", pin_out, 8'h0F);
        reg_read(2'd0, v); check8("R4 readback", v, 8'h0F);
        reg_write(2'd0, 8'hA5);
        check8("R3 all out", pin_out, 8'hA5);
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        reg_write(2'd1, 8'hF0);
        reg_write(2'd0, 8'h30);
        @(negedge clk); pin_in = 8'hC6;
        repeat (3) @(negedge clk);
        reg_read(2'd0, v); check8("R5 mixed read", v, 8'h36);
        @(negedge clk); pin_in = 8'h00;
        repeat (3) @(negedge clk);
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'h00);
    endtask

    task automatic t_rise();
        en = 8'hFF;
        reg_write(2'd2, 8'h01);
        pin_pulse("R6 rising bit0", 8'h01, 8'h01);
        pin_pulse("R6 held level no repeat R10", 8'h01, 8'h00);
        pin_pulse("R6 falling ignored", 8'h00, 8'h00);
    endtask

    task automatic t_fall();
        reg_write(2'd2, 8'h00);
        pin_pulse("R7 rising ignored", 8'h02, 8'h00);
        pin_pulse("R7 falling bit1", 8'h00, 8'h02);
    endtask

    task automatic t_enable();
        reg_write(2'd2, 8'h04);
        en = 8'hFB;
        pin_pulse("R8 gated edge", 8'h04, 8'h00);
        en = 8'hFF;
        pin_pulse("R8 no late pulse", 8'h04, 8'h00);
        pin_pulse("R8 setup back low", 8'h00, 8'h00);
        pin_pulse("R8 enabled edge", 8'h04, 8'h04);
        pin_pulse("R8 return low", 8'h00, 8'h00);
    endtask

    task automatic t_outdir();
        reg_write(2'd2, 8'hFF);
        reg_write(2'd1, 8'hF0);
        pin_pulse("R9 output bits quiet", 8'hF0, 8'h00);
        pin_pulse("R9 input bits still pulse", 8'hFF, 8'h0F);
        pin_pulse("R9 release", 8'h00, 8'h00);
        reg_write(2'd1, 8'h00);
    endtask

    task automatic t_multi();
        reg_write(2'd2, 8'hAA);
        pin_pulse("R10 only rising-select bits", 8'hFF, 8'hAA);
        pin_pulse("R10 only falling-select bits", 8'h00, 8'h55);
        en = 8'h0F;
        pin_pulse("R10 partial enable", 8'hFF, 8'h0A);
        en = 8'hFF;
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_drive();
        t_readback();
        t_rise();
        t_fall();
        t_enable();
        t_outdir();
        t_multi();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule